// File: doc/BRIEF.md
# Selectable Synchronous/Asynchronous Control Stage

This block sits in front of the routing logic of a multi-port datapath switch. It conditions the switch's control inputs. The controls fall into two groups. The first group holds the active-low output enables, one for each of the four A-side ports and one for each of the two X-side ports. The second group holds the datapath controls: the A-side path select, the first-level X-side source select, the X-port select, the Y-port select, the input-register and output-register load enables, and the word-mode bit.

Each group has its own timing-mode pin. When that pin is low, the group's raw inputs reach the routing logic through a purely combinational path. When the pin is high, the routing logic instead sees the values that a capture register sampled on the most recent rising edge of the control clock. A change on a raw input then takes effect one control-clock edge later.

The capture registers sample on every control-clock edge, whatever the mode. A group can therefore be moved into synchronous mode as soon as one edge has passed with its inputs held steady. The stage drives a primed flag. The flag is cleared by reset and goes high at the first control-clock edge after reset.

Top module: `ctl_sync_stage`

## Requirements
- R1: With `oe_mode_sync` low, `oe_n_eff` equals `oe_n_raw` at all times, with no clock edge needed.
- R2: With `oe_mode_sync` high, `oe_n_eff` equals the value that `oe_n_raw` had at the most recent rising edge of `clk_ctl`. A change of `oe_n_raw` between edges does not reach `oe_n_eff` until the next edge.
- R3: With `dp_mode_sync` low, every datapath output (`asel_eff`, `xsrc_eff`, `xport_eff`, `yport_eff`, `ld_in_eff`, `ld_out_eff`, `wide_eff`) equals its raw input combinationally.
- R4: With `dp_mode_sync` high, every datapath output equals its raw input as sampled at the most recent rising edge of `clk_ctl`.
- R5: The two mode pins are independent. `oe_mode_sync` affects only the output-enable group, and `dp_mode_sync` affects only the datapath group.
- R6: The capture registers sample on every `clk_ctl` edge in either mode. Suppose a group's raw inputs have been held steady across at least one edge and its mode pin then rises. The outputs then show those held values at once, with no extra edge.
- R7: While `rst_n` is low, with a group in synchronous mode, the captured output enables read all ones (all ports disabled) and every captured datapath control reads zero.
- R8: `ctl_primed` is low during reset and is still low after reset is released, until the first `clk_ctl` rising edge. It goes high at that edge and stays high until the next reset. Neither mode pin may be high while `ctl_primed` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ctl | input | 1 | Control clock; capture registers sample on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| oe_mode_sync | input | 1 | 1: output enables are taken from the capture register |
| dp_mode_sync | input | 1 | 1: datapath controls are taken from the capture register |
| oe_n_raw | input | 6 | Raw active-low output enables, four A-side ports then X and Y |
| asel_raw | input | 2 | Raw A-side path select |
| xsrc_raw | input | 2 | Raw first-level X-side source select |
| xport_raw | input | 2 | Raw X-port select |
| yport_raw | input | 1 | Raw Y-port select |
| ld_in_raw | input | 4 | Raw input-register load enables |
| ld_out_raw | input | 4 | Raw output-register load enables |
| wide_raw | input | 1 | Raw word-mode bit |
| oe_n_eff | output | 6 | Effective output enables |
| asel_eff | output | 2 | Effective A-side path select |
| xsrc_eff | output | 2 | Effective first-level X-side source select |
| xport_eff | output | 2 | Effective X-port select |
| yport_eff | output | 1 | Effective Y-port select |
| ld_in_eff | output | 4 | Effective input-register load enables |
| ld_out_eff | output | 4 | Effective output-register load enables |
| wide_eff | output | 1 | Effective word-mode bit |
| ctl_primed | output | 1 | High once a control-clock edge has followed reset |

## Verification
The bypass path is swept over every one of the 64 output-enable codes. It is also swept over every one of the 65,536 combinations of the 16 datapath control bits. This shows that no bit is dropped, swapped or inverted on its way through.

In synchronous mode, a sequence of arithmetically spread patterns is checked twice for each pattern: once before the capturing edge and once after it. This separates a real one-edge delay from a bypass that leaks through, and from a register that never updates.

The independence test runs one group in each mode at the same time. The mode-switch test raises a mode pin after the inputs have been held steady across an edge. Reset values are read with both groups forced into synchronous mode while reset is held.

// File: rtl/ctl_stage_pkg.sv
package ctl_stage_pkg;

   typedef enum logic {
      CTL_ASYNC = 1'b0,
      CTL_SYNC  = 1'b1
   } ctl_timing_e;

   function automatic int ctl_sel_width(input int choices);
      return (choices > 1) ? $clog2(choices) : 1;
   endfunction

endpackage

// File: rtl/ctl_capture_reg.sv
module ctl_capture_reg #(
   parameter int   W       = 8,
   parameter logic RST_BIT = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   localparam logic [W-1:0] RST_VAL = {W{RST_BIT}};

   if (W < 1) begin : g_bad_width
      $error("ctl_capture_reg: W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= RST_VAL;
      else        q <= d;
   end

endmodule

// File: rtl/ctl_group_path.sv
module ctl_group_path
   import ctl_stage_pkg::*;
#(
   parameter int   W       = 8,
   parameter logic RST_BIT = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  ctl_timing_e  timing,
   input  logic [W-1:0] raw,
   output logic [W-1:0] eff
);

   logic [W-1:0] held;

   ctl_capture_reg #(
      .W       (W),
      .RST_BIT (RST_BIT)
   ) u_cap (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw),
      .q     (held)
   );

   for (genvar b = 0; b < W; b++) begin : g_lane
      always_comb begin
         unique case (timing)
            CTL_SYNC:  eff[b] = held[b];
            default:   eff[b] = raw[b];
         endcase
      end
   end

endmodule

// File: rtl/ctl_prime_flag.sv
module ctl_prime_flag (
   input  logic clk,
   input  logic rst_n,
   output logic primed
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) primed <= 1'b0;
      else        primed <= 1'b1;
   end

endmodule

// File: rtl/ctl_sync_stage.sv
module ctl_sync_stage
   import ctl_stage_pkg::*;
#(
   parameter int N_SIDE = 4,
   parameter int ASEL_W = 2,
   parameter int XSRC_W = 2,
   parameter int XPORT_W_P = ctl_sel_width(N_SIDE),
   parameter int YPORT_W_P = ctl_sel_width(N_SIDE / 2),
   parameter int N_OE_P    = N_SIDE + 2
) (
   input  logic                 clk_ctl,
   input  logic                 rst_n,
   input  logic                 oe_mode_sync,
   input  logic                 dp_mode_sync,
   input  logic [N_OE_P-1:0]    oe_n_raw,
   input  logic [ASEL_W-1:0]    asel_raw,
   input  logic [XSRC_W-1:0]    xsrc_raw,
   input  logic [XPORT_W_P-1:0] xport_raw,
   input  logic [YPORT_W_P-1:0] yport_raw,
   input  logic [N_SIDE-1:0]    ld_in_raw,
   input  logic [N_SIDE-1:0]    ld_out_raw,
   input  logic                 wide_raw,
   output logic [N_OE_P-1:0]    oe_n_eff,
   output logic [ASEL_W-1:0]    asel_eff,
   output logic [XSRC_W-1:0]    xsrc_eff,
   output logic [XPORT_W_P-1:0] xport_eff,
   output logic [YPORT_W_P-1:0] yport_eff,
   output logic [N_SIDE-1:0]    ld_in_eff,
   output logic [N_SIDE-1:0]    ld_out_eff,
   output logic                 wide_eff,
   output logic                 ctl_primed
);

   localparam int DP_W = ASEL_W + XSRC_W + XPORT_W_P + YPORT_W_P + 2 * N_SIDE + 1;

   if (N_SIDE < 2 || (N_SIDE & (N_SIDE - 1)) != 0) begin : g_bad_side
      $error("ctl_sync_stage: N_SIDE must be a power of two, at least 2");
   end
   if (ASEL_W < 1 || XSRC_W < 1) begin : g_bad_sel
      $error("ctl_sync_stage: select widths must be at least 1");
   end
   if (N_OE_P != N_SIDE + 2) begin : g_bad_oe
      $error("ctl_sync_stage: N_OE_P must equal N_SIDE + 2");
   end

   logic [DP_W-1:0] dp_raw;
   logic [DP_W-1:0] dp_eff;

   assign dp_raw = {wide_raw, ld_out_raw, ld_in_raw, yport_raw,
                    xport_raw, xsrc_raw, asel_raw};

   ctl_group_path #(
      .W       (N_OE_P),
      .RST_BIT (1'b1)
   ) u_oe_grp (
      .clk    (clk_ctl),
      .rst_n  (rst_n),
      .timing (ctl_timing_e'(oe_mode_sync)),
      .raw    (oe_n_raw),
      .eff    (oe_n_eff)
   );

   ctl_group_path #(
      .W       (DP_W),
      .RST_BIT (1'b0)
   ) u_dp_grp (
      .clk    (clk_ctl),
      .rst_n  (rst_n),
      .timing (ctl_timing_e'(dp_mode_sync)),
      .raw    (dp_raw),
      .eff    (dp_eff)
   );

   assign {wide_eff, ld_out_eff, ld_in_eff, yport_eff,
           xport_eff, xsrc_eff, asel_eff} = dp_eff;

   ctl_prime_flag u_prime (
      .clk    (clk_ctl),
      .rst_n  (rst_n),
      .primed (ctl_primed)
   );

endmodule

// File: rtl/ctl_sync_stage_chk.sv
module ctl_sync_stage_chk #(
   parameter int N_OE = 6,
   parameter int DP_W = 16
) (
   input logic            clk_ctl,
   input logic            rst_n,
   input logic            oe_mode_sync,
   input logic            dp_mode_sync,
   input logic [N_OE-1:0] oe_raw,
   input logic [N_OE-1:0] oe_eff,
   input logic [DP_W-1:0] dp_raw,
   input logic [DP_W-1:0] dp_eff,
   input logic            ctl_primed
);

   AST_OE_BYPASS: assert property (@(posedge clk_ctl) disable iff (!rst_n)
      !oe_mode_sync |-> oe_eff == oe_raw); // R1

   AST_OE_CAPTURED: assert property (@(posedge clk_ctl) disable iff (!rst_n)
      (oe_mode_sync && ctl_primed) |-> oe_eff == $past(oe_raw)); // R2

   AST_DP_BYPASS: assert property (@(posedge clk_ctl) disable iff (!rst_n)
      !dp_mode_sync |-> dp_eff == dp_raw); // R3

   AST_DP_CAPTURED: assert property (@(posedge clk_ctl) disable iff (!rst_n)
      (dp_mode_sync && ctl_primed) |-> dp_eff == $past(dp_raw)); // R4

   AST_SYNC_NEEDS_PRIME: assert property (@(posedge clk_ctl) disable iff (!rst_n)
      (oe_mode_sync || dp_mode_sync) |-> ctl_primed); // R8

   AST_PRIME_STICKY: assert property (@(posedge clk_ctl) disable iff (!rst_n)
      ctl_primed |=> ctl_primed); // R8

endmodule

bind ctl_sync_stage ctl_sync_stage_chk #(
   .N_OE (N_OE_P),
   .DP_W (DP_W)
) u_chk (
   .clk_ctl      (clk_ctl),
   .rst_n        (rst_n),
   .oe_mode_sync (oe_mode_sync),
   .dp_mode_sync (dp_mode_sync),
   .oe_raw       (oe_n_raw),
   .oe_eff       (oe_n_eff),
   .dp_raw       (dp_raw),
   .dp_eff       (dp_eff),
   .ctl_primed   (ctl_primed)
);

// File: tb/ctl_sync_stage_tb.sv
module ctl_sync_stage_tb;

   localparam int CLK_T = 10;

   logic       clk_ctl = 1'b0;
   logic       rst_n;
   logic       oe_mode_sync, dp_mode_sync;
   logic [5:0] oe_n_raw, oe_n_eff;
   logic [1:0] asel_raw, xsrc_raw, xport_raw;
   logic [1:0] asel_eff, xsrc_eff, xport_eff;
   logic       yport_raw, yport_eff, wide_raw, wide_eff;
   logic [3:0] ld_in_raw, ld_out_raw, ld_in_eff, ld_out_eff;
   logic       ctl_primed;

   int total = 0;
   int bad   = 0;

   always #(CLK_T/2) clk_ctl = ~clk_ctl;

   ctl_sync_stage u_dut (
      .clk_ctl      (clk_ctl),
      .rst_n        (rst_n),
      .oe_mode_sync (oe_mode_sync),
      .dp_mode_sync (dp_mode_sync),
      .oe_n_raw     (oe_n_raw),
      .asel_raw     (asel_raw),
      .xsrc_raw     (xsrc_raw),
      .xport_raw    (xport_raw),
      .yport_raw    (yport_raw),
      .ld_in_raw    (ld_in_raw),
      .ld_out_raw   (ld_out_raw),
      .wide_raw     (wide_raw),
      .oe_n_eff     (oe_n_eff),
      .asel_eff     (asel_eff),
      .xsrc_eff     (xsrc_eff),
      .xport_eff    (xport_eff),
      .yport_eff    (yport_eff),
      .ld_in_eff    (ld_in_eff),
      .ld_out_eff   (ld_out_eff),
      .wide_eff     (wide_eff),
      .ctl_primed   (ctl_primed)
   );

   // datapath controls as one 16-bit word:
   // {wide, ld_out[3:0], ld_in[3:0], yport, xport[1:0], xsrc[1:0], asel[1:0]}
   task automatic drive_dp(input logic [15:0] v);
      {wide_raw, ld_out_raw, ld_in_raw, yport_raw, xport_raw, xsrc_raw, asel_raw} = v;
   endtask

   function automatic logic [15:0] read_dp();
      return {wide_eff, ld_out_eff, ld_in_eff, yport_eff, xport_eff, xsrc_eff, asel_eff};
   endfunction

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   initial begin : watchdog
      #(CLK_T * 150000);
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : stim
      logic [5:0]  oe_prev;
      logic [15:0] dp_prev;

      // R7: reset values while both groups are forced synchronous
      rst_n = 1'b0;
      oe_mode_sync = 1'b1;
      dp_mode_sync = 1'b1;
      oe_n_raw = 6'h00;
      drive_dp(16'hFFFF);
      repeat (3) @(negedge clk_ctl);
      #1;
      chk("R7 oe reset", {10'd0, oe_n_eff}, 16'h003F);
      chk("R7 dp reset", read_dp(), 16'h0000);
      chk("R8 primed in reset", {15'd0, ctl_primed}, 16'd0);

      // release reset in async mode; primed only after the next edge
      @(negedge clk_ctl);
      oe_mode_sync = 1'b0;
      dp_mode_sync = 1'b0;
      rst_n = 1'b1;
      #1;
      chk("R8 primed before edge", {15'd0, ctl_primed}, 16'd0);
      @(posedge clk_ctl);
      #1;
      chk("R8 primed after edge", {15'd0, ctl_primed}, 16'd1);

      // R1: all 64 output-enable codes through the bypass
      for (int i = 0; i < 64; i++) begin
         oe_n_raw = 6'(i);
         #1;
         chk("R1 oe bypass", {10'd0, oe_n_eff}, 16'(i));
      end

      // R3: every datapath control combination through the bypass
      for (int i = 0; i < 65536; i++) begin
         drive_dp(16'(i));
         #1;
         chk("R3 dp bypass", read_dp(), 16'(i));
      end

      // R6: hold values across an edge, then raise both modes
      @(negedge clk_ctl);
      oe_n_raw = 6'h2A;
      drive_dp(16'hC35A);
      @(negedge clk_ctl);
      oe_mode_sync = 1'b1;
      dp_mode_sync = 1'b1;
      #1;
      chk("R6 oe after switch", {10'd0, oe_n_eff}, 16'h002A);
      chk("R6 dp after switch", read_dp(), 16'hC35A);
      chk("R8 primed stays", {15'd0, ctl_primed}, 16'd1);

      // R2 / R4: one-edge delay for a spread of patterns
      oe_prev = 6'h2A;
      dp_prev = 16'hC35A;
      for (int i = 0; i < 48; i++) begin
         logic [5:0]  oe_v;
         logic [15:0] dp_v;
         oe_v = 6'((i * 13 + 5) % 64);
         dp_v = 16'((i * 40503 + 7) % 65536);
         @(negedge clk_ctl);
         oe_n_raw = oe_v;
         drive_dp(dp_v);
         #1;
         chk("R2 oe holds before edge", {10'd0, oe_n_eff}, {10'd0, oe_prev});
         chk("R4 dp holds before edge", read_dp(), dp_prev);
         @(posedge clk_ctl);
         #1;
         chk("R2 oe after edge", {10'd0, oe_n_eff}, {10'd0, oe_v});
         chk("R4 dp after edge", read_dp(), dp_v);
         oe_prev = oe_v;
         dp_prev = dp_v;
      end

      // R5: output enables synchronous, datapath bypassed
      @(negedge clk_ctl);
      dp_mode_sync = 1'b0;
      oe_n_raw = 6'h11;
      drive_dp(16'h0F0F);
      #1;
      chk("R5 oe sync holds", {10'd0, oe_n_eff}, {10'd0, oe_prev});
      chk("R5 dp follows", read_dp(), 16'h0F0F);
      @(posedge clk_ctl);
      #1;
      chk("R5 oe updates", {10'd0, oe_n_eff}, 16'h0011);

      // R5: output enables bypassed, datapath synchronous
      @(negedge clk_ctl);
      dp_mode_sync = 1'b1;
      #1;
      chk("R5 dp held value", read_dp(), 16'h0F0F);
      oe_mode_sync = 1'b0;
      oe_n_raw = 6'h3C;
      drive_dp(16'hA5A5);
      #1;
      chk("R5 oe follows", {10'd0, oe_n_eff}, 16'h003C);
      chk("R5 dp sync holds", read_dp(), 16'h0F0F);
      @(posedge clk_ctl);
      #1;
      chk("R5 dp updates", read_dp(), 16'hA5A5);

      @(negedge clk_ctl);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule